// File: doc/BRIEF.md
# Multi-block erase scheduler

This block decides which blocks of a seven-block flash array are erased, and in what order. The array is asymmetric. It has three 64 KB blocks, one 32 KB block, two 8 KB blocks and a 16 KB boot block. A build parameter places the boot block at the top or at the bottom of the 256 KB space. An erase confirm carries a byte address. The block decodes that address to a block index and adds the block to an erase set, unless the block is protected. Each confirm also opens or restarts a start window of `TIMEOUT_CYC` clock cycles. The erase begins once the window closes with no new confirm inside it.

When the walk starts, the scheduler visits the selected blocks in ascending index order. It asks the array for two operations on each block: first a pre-program that writes the whole block to 00h, then an erase to FFh. Each operation is a single `arr_go` pulse, and the array answers with a busy pulse. A chip-erase strobe selects every unprotected block and starts the walk at once.

A suspend request is handled at the next operation boundary. A suspend that arrives inside the start window closes the window at once. A resume continues the walk from where it stopped. An abort strobe discards the erase for good. Any failure reported by the array ends the walk.

Top module: `erase_sched`

## Requirements
- R1: With the boot block at the top (default), a 5-bit segment code u = addr[17:13] maps to block indices as follows: u 0..7 → 0, 8..15 → 1, 16..23 → 2, 24..27 → 3, 28 → 4, 29 → 5, 30..31 → 6. Bit i of `set_mask` stands for block i.
- R2: With the boot block at the bottom, the mapping is: u 0..1 → 0, 2 → 1, 3 → 2, 4..7 → 3, 8..15 → 4, 16..23 → 5, 24..31 → 6.
- R3: A confirm on an unprotected block while idle or finished replaces `set_mask` with that single block and raises `window_open` one cycle later.
- R4: A confirm on an unprotected block while `window_open` is high adds that block to the set and restarts the full window. No array operation starts while the window is open.
- R5: A confirm on a protected block (`prot_mask` bit = 1) leaves `set_mask` and the window unchanged. A chip erase never selects a protected block.
- R6: The walk visits the set blocks in ascending index order. Each block gets one `arr_go` with `arr_op`=0 (pre-program), then one with `arr_op`=1 (erase). The next `arr_go` follows only after the array's busy pulse has ended.
- R7: When every set block has been erased, `done` goes high with `fail` low, and `set_mask` keeps the completed set.
- R8: A chip-erase strobe sets `set_mask` to the inverse of `prot_mask` and starts the walk with no window (`window_open` stays low).
- R9: A suspend while the window is open closes the window and raises `suspended` one cycle later, and no operation is issued. A resume then starts the walk.
- R10: A suspend during the walk lets the current operation finish, then raises `suspended`. No `arr_go` occurs while suspended. A resume continues with the remaining operations, in the same order.
- R11: `pgm_ok` is high, one cycle after its inputs, only while suspended and only when `pgm_addr` decodes to a block that is neither in the set nor protected.
- R12: If `arr_fail` is high when an operation's busy pulse ends, `fail` and `done` go high and no further `arr_go` is issued.
- R13: An abort strobe in any state clears `set_mask`, `window_open`, `suspended`, `done` and `fail` after one cycle. No further operation of that erase is issued.
- R14: Confirms and chip-erase strobes have no effect on `set_mask` while the walk is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfm_stb | input | 1 | Block erase confirm strobe |
| cfm_addr | input | ADDR_W | Byte address inside the block to erase |
| chip_stb | input | 1 | Chip erase strobe |
| susp_stb | input | 1 | Suspend request strobe |
| resm_stb | input | 1 | Resume request strobe |
| abort_stb | input | 1 | Abort (read/reset) strobe |
| prot_mask | input | 7 | Protection bitmap, 1 = protected |
| pgm_addr | input | ADDR_W | Address of an intended program during suspend |
| arr_busy | input | 1 | Array busy with the current operation |
| arr_fail | input | 1 | Array failure, valid when busy ends |
| arr_go | output | 1 | One-cycle operation start pulse |
| arr_op | output | 1 | 0 = pre-program to 00h, 1 = erase to FFh |
| arr_blk | output | 3 | Block index of the operation |
| set_mask | output | 7 | Current erase set |
| window_open | output | 1 | Start window timer running |
| suspended | output | 1 | Erase suspended |
| done | output | 1 | Erase sequence finished |
| fail | output | 1 | Erase sequence ended on an array failure |
| pgm_ok | output | 1 | Program at `pgm_addr` permitted during suspend |

## Verification
The address decode is swept over all 32 segment codes on a top-boot and a bottom-boot instance at the same time, so a boundary that is off by one shows up in only one of the two maps. The walk is driven three ways, and the bench logs every `arr_go` to check the order: a late confirm restarts the window after an early confirm on a higher block, which separates ascending order from arrival order and shows that the window restarted; a chip erase under a sparse protection map separates exclusion from selection; and explicit window expiry. Suspend is tried inside the window and again between a pre-program and its erase. The second case tells whether the remaining phase is kept, and together they check the program-permission output. Failure injection and abort in the middle of a walk confirm that operations stop.

// File: rtl/es_pkg.sv
package es_pkg;
  localparam int NBLK = 7;
  localparam int BIW  = $clog2(NBLK);
  localparam int SEG_W = 5;

  typedef logic [NBLK-1:0] blkmask_t;
  typedef logic [BIW-1:0]  blkidx_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WIN, ST_PICK, ST_GO, ST_WAIT, ST_SUSP, ST_END
  } wst_t;

  typedef enum logic {
    PH_ZERO = 1'b0,
    PH_WIPE = 1'b1
  } phase_t;

  function automatic blkidx_t lowest_set(blkmask_t m);
    blkidx_t r;
    r = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (m[i]) r = blkidx_t'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/es_decode.sv
module es_decode
  import es_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter bit BOOT_TOP = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output blkidx_t           idx
);
  localparam int LOW_W = ADDR_W - SEG_W;

  logic [SEG_W-1:0] seg;
  logic             unused_low;

  assign seg        = addr[ADDR_W-1 -: SEG_W];
  assign unused_low = ^addr[LOW_W-1:0];

  generate
    if (BOOT_TOP) begin : g_top
      always_comb begin
        if (seg < 5'd8)        idx = blkidx_t'(0);
        else if (seg < 5'd16)  idx = blkidx_t'(1);
        else if (seg < 5'd24)  idx = blkidx_t'(2);
        else if (seg < 5'd28)  idx = blkidx_t'(3);
        else if (seg == 5'd28) idx = blkidx_t'(4);
        else if (seg == 5'd29) idx = blkidx_t'(5);
        else                   idx = blkidx_t'(6);
      end
    end else begin : g_bot
      always_comb begin
        if (seg < 5'd2)        idx = blkidx_t'(0);
        else if (seg == 5'd2)  idx = blkidx_t'(1);
        else if (seg == 5'd3)  idx = blkidx_t'(2);
        else if (seg < 5'd8)   idx = blkidx_t'(3);
        else if (seg < 5'd16)  idx = blkidx_t'(4);
        else if (seg < 5'd24)  idx = blkidx_t'(5);
        else                   idx = blkidx_t'(6);
      end
    end
  endgenerate
endmodule

// File: rtl/es_timer.sv
module es_timer #(
  parameter int TIMEOUT_CYC = 17000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cancel,
  output logic running,
  output logic expire
);
  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || cancel) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= CW'(TIMEOUT_CYC - 1);
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  assign expire = running && (cnt == '0);

  // R4: a (re)start always leaves the window open on the next cycle
  assert_restart_opens_R4: assert property (@(posedge clk) disable iff (rst)
    (start && !cancel) |=> running)
    else $error("window not open after start");

  // R9: a cancel always closes the window
  assert_cancel_closes_R9: assert property (@(posedge clk) disable iff (rst)
    cancel |=> !running)
    else $error("window still open after cancel");
endmodule

// File: rtl/es_walker.sv
module es_walker
  import es_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfm_stb,
  input  blkidx_t  cfm_idx,
  input  logic     chip_stb,
  input  logic     susp_stb,
  input  logic     resm_stb,
  input  logic     abort_stb,
  input  blkmask_t prot,
  input  logic     win_exp,
  output logic     win_start,
  output logic     win_cancel,
  input  logic     arr_busy,
  input  logic     arr_fail,
  output logic     arr_go,
  output logic     arr_op,
  output blkidx_t  arr_blk,
  output blkmask_t set_mask,
  output logic     suspended,
  output logic     done,
  output logic     fail
);
  wst_t     st;
  phase_t   phase;
  blkmask_t pend;
  blkidx_t  cur;
  logic     seen_busy;
  logic     susp_pend;

  logic     cfm_ok;
  blkmask_t cfm_bit;
  blkmask_t chip_set;
  logic     chip_ok;
  logic     susp_now;

  assign cfm_bit  = blkmask_t'(1) << cfm_idx;
  assign cfm_ok   = cfm_stb && !prot[cfm_idx];
  assign chip_set = ~prot;
  assign chip_ok  = chip_stb && (chip_set != '0);
  assign susp_now = susp_pend || susp_stb;

  always_comb begin
    win_start  = 1'b0;
    win_cancel = 1'b0;
    if (abort_stb) begin
      win_cancel = 1'b1;
    end else begin
      case (st)
        ST_IDLE, ST_END: begin
          if (!chip_ok && cfm_ok) win_start = 1'b1;
        end
        ST_WIN: begin
          if (susp_stb || chip_ok) win_cancel = 1'b1;
          else if (cfm_ok)         win_start  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort_stb) begin
      st        <= ST_IDLE;
      phase     <= PH_ZERO;
      pend      <= '0;
      set_mask  <= '0;
      cur       <= '0;
      seen_busy <= 1'b0;
      susp_pend <= 1'b0;
      fail      <= 1'b0;
      arr_go    <= 1'b0;
      arr_op    <= 1'b0;
      arr_blk   <= '0;
    end else begin
      arr_go <= 1'b0;
      case (st)
        ST_IDLE, ST_END: begin
          if (chip_ok) begin
            set_mask  <= chip_set;
            pend      <= chip_set;
            fail      <= 1'b0;
            phase     <= PH_ZERO;
            susp_pend <= 1'b0;
            st        <= ST_PICK;
          end else if (cfm_ok) begin
            set_mask  <= cfm_bit;
            fail      <= 1'b0;
            phase     <= PH_ZERO;
            susp_pend <= 1'b0;
            st        <= ST_WIN;
          end
        end
        ST_WIN: begin
          if (susp_stb) begin
            pend <= set_mask;
            st   <= ST_SUSP;
          end else if (chip_ok) begin
            set_mask <= chip_set;
            pend     <= chip_set;
            st       <= ST_PICK;
          end else if (cfm_ok) begin
            set_mask <= set_mask | cfm_bit;
          end else if (win_exp) begin
            pend <= set_mask;
            st   <= ST_PICK;
          end
        end
        ST_PICK: begin
          if (pend == '0) begin
            st        <= ST_END;
            susp_pend <= 1'b0;
          end else if (susp_now) begin
            st        <= ST_SUSP;
            susp_pend <= 1'b0;
          end else begin
            cur <= lowest_set(pend);
            st  <= ST_GO;
          end
        end
        ST_GO: begin
          susp_pend <= susp_now;
          arr_go    <= 1'b1;
          arr_op    <= phase;
          arr_blk   <= cur;
          seen_busy <= 1'b0;
          st        <= ST_WAIT;
        end
        ST_WAIT: begin
          susp_pend <= susp_now;
          if (arr_busy) begin
            seen_busy <= 1'b1;
          end else if (seen_busy) begin
            if (arr_fail) begin
              fail      <= 1'b1;
              susp_pend <= 1'b0;
              st        <= ST_END;
            end else if (phase == PH_ZERO) begin
              phase <= PH_WIPE;
              if (susp_now) begin
                susp_pend <= 1'b0;
                st        <= ST_SUSP;
              end else begin
                st <= ST_GO;
              end
            end else begin
              pend[cur] <= 1'b0;
              phase     <= PH_ZERO;
              st        <= ST_PICK;
            end
          end
        end
        ST_SUSP: begin
          if (resm_stb) st <= (phase == PH_WIPE) ? ST_GO : ST_PICK;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign suspended = (st == ST_SUSP);
  assign done      = (st == ST_END);

  // R6: the start of an operation is a single-cycle pulse
  assert_go_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    arr_go |=> !arr_go)
    else $error("arr_go longer than one cycle");

  // R6: operations only target blocks of the erase set
  assert_go_in_set_R6: assert property (@(posedge clk) disable iff (rst)
    arr_go |-> set_mask[arr_blk])
    else $error("operation outside the erase set");

  // R10: nothing is started while suspended
  assert_no_go_suspended_R10: assert property (@(posedge clk) disable iff (rst)
    suspended |-> !arr_go)
    else $error("operation started while suspended");

  // R12: a failure always ends the sequence
  assert_fail_ends_R12: assert property (@(posedge clk) disable iff (rst)
    fail |-> done)
    else $error("fail without done");

  // R13: abort wipes the erase state
  assert_abort_clears_R13: assert property (@(posedge clk) disable iff (rst)
    abort_stb |=> (set_mask == '0 && !done && !fail && !suspended))
    else $error("state left after abort");
endmodule

// File: rtl/erase_sched.sv
module erase_sched
  import es_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter bit BOOT_TOP    = 1'b1,
  parameter int TIMEOUT_CYC = 17000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfm_stb,
  input  logic [ADDR_W-1:0] cfm_addr,
  input  logic              chip_stb,
  input  logic              susp_stb,
  input  logic              resm_stb,
  input  logic              abort_stb,
  input  logic [NBLK-1:0]   prot_mask,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic              arr_busy,
  input  logic              arr_fail,
  output logic              arr_go,
  output logic              arr_op,
  output logic [BIW-1:0]    arr_blk,
  output logic [NBLK-1:0]   set_mask,
  output logic              window_open,
  output logic              suspended,
  output logic              done,
  output logic              fail,
  output logic              pgm_ok
);
  blkidx_t cfm_idx;
  blkidx_t pgm_idx;
  logic    win_start;
  logic    win_cancel;
  logic    win_exp;

  es_decode #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) u_dec_cfm (
    .addr (cfm_addr),
    .idx  (cfm_idx)
  );

  es_decode #(.ADDR_W(ADDR_W), .BOOT_TOP(BOOT_TOP)) u_dec_pgm (
    .addr (pgm_addr),
    .idx  (pgm_idx)
  );

  es_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (win_start),
    .cancel  (win_cancel),
    .running (window_open),
    .expire  (win_exp)
  );

  es_walker u_walk (
    .clk        (clk),
    .rst        (rst),
    .cfm_stb    (cfm_stb),
    .cfm_idx    (cfm_idx),
    .chip_stb   (chip_stb),
    .susp_stb   (susp_stb),
    .resm_stb   (resm_stb),
    .abort_stb  (abort_stb),
    .prot       (prot_mask),
    .win_exp    (win_exp),
    .win_start  (win_start),
    .win_cancel (win_cancel),
    .arr_busy   (arr_busy),
    .arr_fail   (arr_fail),
    .arr_go     (arr_go),
    .arr_op     (arr_op),
    .arr_blk    (arr_blk),
    .set_mask   (set_mask),
    .suspended  (suspended),
    .done       (done),
    .fail       (fail)
  );

  always_ff @(posedge clk) begin
    if (rst) pgm_ok <= 1'b0;
    else     pgm_ok <= suspended && !set_mask[pgm_idx] && !prot_mask[pgm_idx];
  end

  // R9: a suspended erase never has its start window running
  assert_susp_no_window_R9: assert property (@(posedge clk) disable iff (rst)
    suspended |-> !window_open)
    else $error("window open while suspended");

  // R4: the walk does not start while the window is open
  assert_no_go_in_window_R4: assert property (@(posedge clk) disable iff (rst)
    window_open |-> !arr_go)
    else $error("operation during start window");
endmodule

// File: tb/tb_erase_sched.sv
module tb_erase_sched;
  localparam int AW  = 18;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfm_stb = 0, chip_stb = 0, susp_stb = 0, resm_stb = 0, abort_stb = 0;
  logic [AW-1:0] cfm_addr = '0, pgm_addr = '0;
  logic [6:0] prot_mask = '0;
  logic arr_busy, arr_fail, arr_go, arr_op;
  logic [2:0] arr_blk;
  logic [6:0] set_mask;
  logic window_open, suspended, done, fail, pgm_ok;

  logic b_go, b_op, b_win, b_susp, b_done, b_fail, b_pok;
  logic [2:0] b_blk;
  logic [6:0] b_set;

  int checks = 0, errors = 0;
  int log_n = 0, fail_at = -1, cur_op = 0, cnt = 0;
  logic log_op [0:63];
  logic [2:0] log_blk [0:63];

  always #2.5 clk = ~clk;

  erase_sched #(.ADDR_W(AW), .BOOT_TOP(1'b1), .TIMEOUT_CYC(TMO)) dut (
    .clk(clk), .rst(rst), .cfm_stb(cfm_stb), .cfm_addr(cfm_addr), .chip_stb(chip_stb),
    .susp_stb(susp_stb), .resm_stb(resm_stb), .abort_stb(abort_stb), .prot_mask(prot_mask),
    .pgm_addr(pgm_addr), .arr_busy(arr_busy), .arr_fail(arr_fail), .arr_go(arr_go),
    .arr_op(arr_op), .arr_blk(arr_blk), .set_mask(set_mask), .window_open(window_open),
    .suspended(suspended), .done(done), .fail(fail), .pgm_ok(pgm_ok));

  erase_sched #(.ADDR_W(AW), .BOOT_TOP(1'b0), .TIMEOUT_CYC(TMO)) dut_b (
    .clk(clk), .rst(rst), .cfm_stb(cfm_stb), .cfm_addr(cfm_addr), .chip_stb(chip_stb),
    .susp_stb(susp_stb), .resm_stb(resm_stb), .abort_stb(abort_stb), .prot_mask(prot_mask),
    .pgm_addr(pgm_addr), .arr_busy(1'b0), .arr_fail(1'b0), .arr_go(b_go),
    .arr_op(b_op), .arr_blk(b_blk), .set_mask(b_set), .window_open(b_win),
    .suspended(b_susp), .done(b_done), .fail(b_fail), .pgm_ok(b_pok));

  // behavioural array: busy for a few cycles after each start, logs every start
  always @(posedge clk) begin
    if (rst) begin
      arr_busy <= 1'b0;
      arr_fail <= 1'b0;
      cnt      <= 0;
    end else if (arr_go) begin
      arr_busy       <= 1'b1;
      cnt            <= 3;
      log_op[log_n]  <= arr_op;
      log_blk[log_n] <= arr_blk;
      cur_op         <= log_n;
      log_n          <= log_n + 1;
    end else if (arr_busy) begin
      if (cnt == 0) begin
        arr_busy <= 1'b0;
        arr_fail <= (cur_op == fail_at);
      end else begin
        cnt <= cnt - 1;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [AW-1:0] seg_addr(int u);
    return AW'(u) << (AW - 5);
  endfunction

  function automatic logic [AW-1:0] top_addr(int blk);
    int u_of [7] = '{0, 8, 16, 24, 28, 29, 30};
    return seg_addr(u_of[blk]) | AW'(12'h5a5);
  endfunction

  function automatic int exp_top(int u);
    if (u < 8) return 0;
    if (u < 16) return 1;
    if (u < 24) return 2;
    if (u < 28) return 3;
    if (u == 28) return 4;
    if (u == 29) return 5;
    return 6;
  endfunction

  function automatic int exp_bot(int u);
    if (u < 2) return 0;
    if (u == 2) return 1;
    if (u == 3) return 2;
    if (u < 8) return 3;
    if (u < 16) return 4;
    if (u < 24) return 5;
    return 6;
  endfunction

  task automatic pulse_cfm(logic [AW-1:0] a);
    cfm_addr = a; cfm_stb = 1'b1; cyc(1); cfm_stb = 1'b0;
  endtask
  task automatic pulse_chip();  chip_stb = 1'b1;  cyc(1); chip_stb = 1'b0;  endtask
  task automatic pulse_susp();  susp_stb = 1'b1;  cyc(1); susp_stb = 1'b0;  endtask
  task automatic pulse_resm();  resm_stb = 1'b1;  cyc(1); resm_stb = 1'b0;  endtask
  task automatic pulse_abort(); abort_stb = 1'b1; cyc(1); abort_stb = 1'b0; endtask

  task automatic wait_done();
    for (int i = 0; i < 2000 && !done; i++) cyc(1);
  endtask

  task automatic wait_ops(int target);
    for (int i = 0; i < 500 && log_n < target; i++) cyc(1);
  endtask

  task automatic check_log(string req, int base, int idx, int op, int blk);
    check({req, " op"}, log_op[base+idx], op);
    check({req, " blk"}, log_blk[base+idx], blk);
  endtask

  task automatic t_reset_state();
    check("R13 reset set", set_mask, 0);
    check("R13 reset win", window_open, 0);
    check("R13 reset susp", suspended, 0);
    check("R13 reset done", done, 0);
    check("R13 reset fail", fail, 0);
    check("R11 reset pgm_ok", pgm_ok, 0);
  endtask

  task automatic t_decode();
    prot_mask = '0;
    for (int u = 0; u < 32; u++) begin
      pulse_abort();
      pulse_cfm(seg_addr(u) | AW'(u * 37));
      check("R1 top decode", set_mask, 1 << exp_top(u));
      check("R2 bottom decode", b_set, 1 << exp_bot(u));
    end
    pulse_abort();
    cyc(2);
  endtask

  task automatic t_window_order();
    int base;
    base = log_n;
    prot_mask = '0;
    pulse_cfm(top_addr(4));
    check("R3 first set", set_mask, 7'b0010000);
    check("R3 window open", window_open, 1);
    cyc(10);
    pulse_cfm(top_addr(1));
    check("R4 added set", set_mask, 7'b0010010);
    cyc(10);
    check("R4 window restarted", window_open, 1);
    check("R4 no op in window", log_n - base, 0);
    wait_ops(base + 1);
    pulse_cfm(top_addr(6));
    pulse_chip();
    check("R14 set frozen in walk", set_mask, 7'b0010010);
    wait_done();
    check("R7 done", done, 1);
    check("R7 no fail", fail, 0);
    check("R7 set kept", set_mask, 7'b0010010);
    check("R6 op count", log_n - base, 4);
    check_log("R6 0", base, 0, 0, 1);
    check_log("R6 1", base, 1, 1, 1);
    check_log("R6 2", base, 2, 0, 4);
    check_log("R6 3", base, 3, 1, 4);
  endtask

  task automatic t_protect_chip();
    int base;
    pulse_abort();
    prot_mask = 7'b0001000;
    pulse_cfm(top_addr(3));
    check("R5 protected ignored set", set_mask, 0);
    check("R5 protected ignored win", window_open, 0);
    base = log_n;
    prot_mask = 7'b1010101;
    pulse_chip();
    check("R8 chip set", set_mask, 7'b0101010);
    check("R8 no window", window_open, 0);
    wait_done();
    check("R8 op count", log_n - base, 6);
    check_log("R5 R8 0", base, 0, 0, 1);
    check_log("R5 R8 1", base, 1, 1, 1);
    check_log("R5 R8 2", base, 2, 0, 3);
    check_log("R5 R8 3", base, 3, 1, 3);
    check_log("R5 R8 4", base, 4, 0, 5);
    check_log("R5 R8 5", base, 5, 1, 5);
  endtask

  task automatic t_susp_window();
    int base;
    pulse_abort();
    prot_mask = '0;
    base = log_n;
    pulse_cfm(top_addr(5));
    cyc(3);
    pulse_susp();
    check("R9 suspended", suspended, 1);
    check("R9 window closed", window_open, 0);
    cyc(30);
    check("R9 no op", log_n - base, 0);
    pgm_addr = top_addr(5); cyc(1);
    check("R11 set block denied", pgm_ok, 0);
    pgm_addr = top_addr(0); cyc(1);
    check("R11 free block allowed", pgm_ok, 1);
    pulse_resm();
    wait_done();
    check("R9 ops after resume", log_n - base, 2);
    check_log("R9 0", base, 0, 0, 5);
    check_log("R9 1", base, 1, 1, 5);
  endtask

  task automatic t_susp_run();
    int base;
    pulse_abort();
    prot_mask = 7'b0001000;
    base = log_n;
    pulse_cfm(top_addr(0));
    pulse_cfm(top_addr(1));
    wait_ops(base + 1);
    pulse_susp();
    cyc(20);
    check("R10 suspended", suspended, 1);
    check("R10 one op only", log_n - base, 1);
    pgm_addr = top_addr(2); cyc(1);
    check("R11 outside set", pgm_ok, 1);
    pgm_addr = top_addr(3); cyc(1);
    check("R11 protected", pgm_ok, 0);
    pgm_addr = top_addr(0); cyc(1);
    check("R11 in set", pgm_ok, 0);
    cyc(20);
    check("R10 still one op", log_n - base, 1);
    pulse_resm();
    wait_done();
    check("R10 total ops", log_n - base, 4);
    check_log("R10 0", base, 0, 0, 0);
    check_log("R10 1", base, 1, 1, 0);
    check_log("R10 2", base, 2, 0, 1);
    check_log("R10 3", base, 3, 1, 1);
    pgm_addr = top_addr(2); cyc(1);
    check("R11 not suspended", pgm_ok, 0);
  endtask

  task automatic t_fail();
    int base;
    pulse_abort();
    prot_mask = '0;
    base = log_n;
    fail_at = base + 1;
    pulse_cfm(top_addr(2));
    pulse_cfm(top_addr(5));
    wait_done();
    check("R12 fail", fail, 1);
    check("R12 done", done, 1);
    cyc(30);
    check("R12 stopped", log_n - base, 2);
    fail_at = -1;
  endtask

  task automatic t_abort();
    int base;
    pulse_abort();
    cyc(8);
    prot_mask = '0;
    base = log_n;
    pulse_cfm(top_addr(6));
    wait_ops(base + 1);
    pulse_abort();
    check("R13 set cleared", set_mask, 0);
    check("R13 done low", done, 0);
    check("R13 susp low", suspended, 0);
    check("R13 win low", window_open, 0);
    cyc(40);
    check("R13 no more ops", log_n - base, 1);
  endtask

  initial begin
    cyc(4);
    rst = 1'b0;
    cyc(1);
    t_reset_state();
    t_decode();
    t_window_order();
    t_protect_chip();
    t_susp_window();
    t_susp_run();
    t_fail();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule